// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Core

This block is a single-port synchronous static memory for use as a small on-chip store or as a bus-accurate memory model. Every enabled rising clock edge samples a command made of an operation type, an address, three chip selects and per-lane byte write enables. A read returns its word in the cycle after the command edge (flow-through). A write takes its data from the data bus one enabled edge after its command. Because read and write latency match, reads and writes can follow each other in any order without an idle bus cycle.

A burst-continue input reuses the operation and selection of the last fresh command and steps an internal 4-beat address counter. The counter runs in wrap-around linear order or in XOR (interleaved) order, and the order is chosen when the burst starts. An active-low clock enable freezes all state, including a write that is waiting for its data. The read port has no real tri-state. A `rvalid` flag stands for "driving", and `rdata` is zero whenever the flag is low. The flag follows the output enable combinationally.

Top module: `ztsram_core`

## Requirements
- R1: When `clk_en_n` is low, an edge with a fresh command (`adv` low, all `chip_sel_n` bits low) and `we_n` low registers a write. The data for that write is taken from `wdata` at the next edge that also has `clk_en_n` low.
- R2: An edge with a fresh selected command and `we_n` high registers a read. From just after that edge until the next enabled edge, `rvalid` is 1 and `rdata` holds the stored word, provided `oe_n` is low.
- R3: Reads and writes can be issued on consecutive edges in any order. A read of an address whose write data was captured at the same edge or at any earlier edge returns the new data, even though that data has not yet been committed to the array.
- R4: `byte_we_n` is active low and is sampled with every write command. Bit 0 guards `wdata[8:0]` and bit 1 guards `wdata[17:9]`. A lane whose bit is high keeps its old content. `2'b00` writes the full word.
- R5: An enabled edge with `adv` high ignores `addr`, `chip_sel_n` and `we_n`. It moves to the next beat of a 4-beat burst. In linear order (`order_ilv`=0), the low two address bits are (start + beat) mod 4. The upper address bits stay those of the start address.
- R6: In interleaved order (`order_ilv`=1 at the start edge), the low two address bits of each beat are the low two bits of the start address XOR the beat count.
- R7: A burst beat keeps the operation type (read or write) of the command that started the burst. `adv` high while the device is deselected keeps it deselected: `rvalid` stays 0 and nothing is written.
- R8: An edge with `clk_en_n` high changes nothing. The current burst position, any read in progress and its output are held. A pending write waits for the next enabled edge to take its data.
- R9: A fresh command with any `chip_sel_n` bit high deselects the device. `rvalid` is 0, `rdata` is zero and no write takes place, whatever `we_n` is.
- R10: `oe_n` acts without a clock. While it is high, `rvalid` is 0 and `rdata` is zero. When it goes low again, the held read data comes back. It has no effect on writes.
- R11: While `rst_n` is low, and after it is released, the device is deselected with no pending write. A write whose data had not been captured before reset is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clk_en_n | input | 1 | Active-low clock enable; high stalls everything |
| chip_sel_n | input | 3 | Chip selects, all must be low to select |
| adv | input | 1 | Burst continue; high ignores addr, chip_sel_n, we_n |
| we_n | input | 1 | Low = write, high = read |
| byte_we_n | input | 2 | Active-low lane write enables |
| order_ilv | input | 1 | Burst order at burst start: 0 linear, 1 interleaved |
| addr | input | 6 | Word address |
| wdata | input | 18 | Write data, one enabled edge after its command |
| oe_n | input | 1 | Asynchronous active-low output enable |
| rdata | output | 18 | Read data, zero when not driving |
| rvalid | output | 1 | High when the port drives data (low stands for high-Z) |

## Verification
A wrong internal state shows at the ports within one or two enabled edges. A wrong burst counter or selection state changes `rvalid` or the word read in the cycle right after the bad edge. A lost or misrouted pending write shows up on the first read of the affected address, at the latest once the write has been committed. The bench keeps its own reference memory and command state, built only from the requirements. It compares `rvalid` and `rdata` after every edge, using a vector table, several thousand randomly mixed reads, writes, bursts, stalls and deselects, and directed cases for the output enable and for reset during a pending write.

// File: rtl/ztsram_pkg.sv
`timescale 1ns/1ps
package ztsram_pkg;

  typedef enum logic {
    KIND_READ  = 1'b0,
    KIND_WRITE = 1'b1
  } xfer_kind_e;

  typedef enum logic {
    ORDER_LINEAR      = 1'b0,
    ORDER_INTERLEAVED = 1'b1
  } burst_order_e;

endpackage

// File: rtl/ztsram_cmd.sv
`timescale 1ns/1ps
module ztsram_cmd
  import ztsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BEAT_W = 2,
  parameter int CS_NUM = 3,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CS_NUM-1:0] cs_n,
  input  logic              adv,
  input  logic              we_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic              order,
  input  logic [ADDR_W-1:0] addr,
  output logic              sel_o,
  output xfer_kind_e        kind_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LANES-1:0]  bw_n_o
);

  localparam int UPPER_W = ADDR_W - BEAT_W;

  logic              sel_q, sel_d;
  xfer_kind_e        kind_q, kind_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  burst_order_e      order_q, order_d;
  logic [LANES-1:0]  bw_q, bw_d;
  logic [BEAT_W-1:0] low_bits;

  // next-state: fresh command or burst continuation
  always_comb begin
    sel_d   = sel_q;
    kind_d  = kind_q;
    base_d  = base_q;
    beat_d  = beat_q;
    order_d = order_q;
    bw_d    = bw_q;
    if (en) begin
      if (adv) begin
        if (sel_q) begin
          beat_d = beat_q + 1'b1;
          bw_d   = bw_n;
        end
      end else begin
        sel_d   = ~|cs_n;
        kind_d  = we_n ? KIND_READ : KIND_WRITE;
        base_d  = addr;
        beat_d  = '0;
        order_d = order ? ORDER_INTERLEAVED : ORDER_LINEAR;
        bw_d    = bw_n;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= 1'b0;
      kind_q  <= KIND_READ;
      base_q  <= '0;
      beat_q  <= '0;
      order_q <= ORDER_LINEAR;
      bw_q    <= '1;
    end else begin
      sel_q   <= sel_d;
      kind_q  <= kind_d;
      base_q  <= base_d;
      beat_q  <= beat_d;
      order_q <= order_d;
      bw_q    <= bw_d;
    end
  end

  // beat address: linear wrap or XOR sequence
  always_comb begin
    if (order_q == ORDER_INTERLEAVED) low_bits = base_q[BEAT_W-1:0] ^ beat_q;
    else                              low_bits = base_q[BEAT_W-1:0] + beat_q;
  end

  generate
    if (UPPER_W > 0) begin : g_upper
      assign addr_o = {base_q[ADDR_W-1:BEAT_W], low_bits};
    end else begin : g_no_upper
      assign addr_o = low_bits;
    end
  endgenerate

  assign sel_o  = sel_q;
  assign kind_o = kind_q;
  assign bw_n_o = bw_q;

  // R8: a stalled edge leaves the command state untouched
  a_r8_stall_holds_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(sel_q) && $stable(base_q) && $stable(beat_q) && $stable(kind_q));

  // R7: burst continue while deselected stays deselected
  a_r7_adv_keeps_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    en && adv && !sel_q |=> !sel_q);

  // R5: a beat steps the counter and keeps the start address
  a_r5_beat_steps: assert property (@(posedge clk) disable iff (!rst_n)
    en && adv && sel_q |=> $stable(base_q) && $stable(kind_q)
                         && beat_q == BEAT_W'($past(beat_q) + 1'b1));

endmodule

// File: rtl/ztsram_wbuf.sv
`timescale 1ns/1ps
module ztsram_wbuf #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LANES-1:0]  cmd_bw_n,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] mem_rword,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [LANES-1:0]  mem_wlane_n,
  output logic [WORD_W-1:0] mem_wword,
  output logic [WORD_W-1:0] rd_word
);

  logic              pv_q, pv_d;
  logic [ADDR_W-1:0] pa_q, pa_d;
  logic [LANES-1:0]  pbw_q, pbw_d;
  logic [WORD_W-1:0] pd_q, pd_d;
  logic              hit;

  // a registered write takes the bus data at the next enabled edge
  always_comb begin
    pv_d  = pv_q;
    pa_d  = pa_q;
    pbw_d = pbw_q;
    pd_d  = pd_q;
    if (en) begin
      pv_d = cmd_write;
      if (cmd_write) begin
        pa_d  = cmd_addr;
        pbw_d = cmd_bw_n;
        pd_d  = wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv_q  <= 1'b0;
      pa_q  <= '0;
      pbw_q <= '1;
      pd_q  <= '0;
    end else begin
      pv_q  <= pv_d;
      pa_q  <= pa_d;
      pbw_q <= pbw_d;
      pd_q  <= pd_d;
    end
  end

  // commit the held word on the next enabled edge
  assign mem_we      = en && pv_q;
  assign mem_waddr   = pa_q;
  assign mem_wlane_n = pbw_q;
  assign mem_wword   = pd_q;

  // forward uncommitted lanes to a read of the same word
  assign hit = pv_q && (pa_q == cmd_addr);

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_fwd
      assign rd_word[l*LANE_W +: LANE_W] = (hit && !pbw_q[l]) ? pd_q[l*LANE_W +: LANE_W]
                                                              : mem_rword[l*LANE_W +: LANE_W];
    end
  endgenerate

  // R1: a write command leads to a captured word one enabled edge later
  a_r1_data_captured: assert property (@(posedge clk) disable iff (!rst_n)
    en && cmd_write |=> pv_q && pd_q == $past(wdata));

  // R8: a stall keeps the pending write and its data
  a_r8_pending_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !en && pv_q |=> pv_q && $stable(pa_q) && $stable(pd_q) && $stable(pbw_q));

endmodule

// File: rtl/ztsram_array.sv
`timescale 1ns/1ps
module ztsram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [LANES-1:0]  wlane_n,
  input  logic [WORD_W-1:0] wword,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rword
);

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] cells [DEPTH];

      always_ff @(posedge clk) begin
        if (we && !wlane_n[l]) begin
          cells[waddr] <= wword[l*LANE_W +: LANE_W];
        end
      end

      assign rword[l*LANE_W +: LANE_W] = cells[raddr];
    end
  endgenerate

endmodule

// File: rtl/ztsram_core.sv
`timescale 1ns/1ps
module ztsram_core
  import ztsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  parameter int BEAT_W = 2,
  parameter int CS_NUM = 3,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_n,
  input  logic [CS_NUM-1:0] chip_sel_n,
  input  logic              adv,
  input  logic              we_n,
  input  logic [LANES-1:0]  byte_we_n,
  input  logic              order_ilv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              oe_n,
  output logic [WORD_W-1:0] rdata,
  output logic              rvalid
);

  logic              rst_meta_n, rst_sync_n;
  logic              en;
  logic              sel;
  xfer_kind_e        kind;
  logic [ADDR_W-1:0] cur_addr;
  logic [LANES-1:0]  cur_bw_n;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [LANES-1:0]  mem_wlane_n;
  logic [WORD_W-1:0] mem_wword;
  logic [WORD_W-1:0] mem_rword;
  logic [WORD_W-1:0] rd_word;
  logic              drive;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  assign en = !clk_en_n;

  ztsram_cmd #(
    .ADDR_W (ADDR_W),
    .BEAT_W (BEAT_W),
    .CS_NUM (CS_NUM),
    .LANES  (LANES)
  ) i_cmd (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .en     (en),
    .cs_n   (chip_sel_n),
    .adv    (adv),
    .we_n   (we_n),
    .bw_n   (byte_we_n),
    .order  (order_ilv),
    .addr   (addr),
    .sel_o  (sel),
    .kind_o (kind),
    .addr_o (cur_addr),
    .bw_n_o (cur_bw_n)
  );

  ztsram_wbuf #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES),
    .LANE_W (LANE_W)
  ) i_wbuf (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .en          (en),
    .cmd_write   (sel && (kind == KIND_WRITE)),
    .cmd_addr    (cur_addr),
    .cmd_bw_n    (cur_bw_n),
    .wdata       (wdata),
    .mem_rword   (mem_rword),
    .mem_we      (mem_we),
    .mem_waddr   (mem_waddr),
    .mem_wlane_n (mem_wlane_n),
    .mem_wword   (mem_wword),
    .rd_word     (rd_word)
  );

  ztsram_array #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES),
    .LANE_W (LANE_W)
  ) i_array (
    .clk     (clk),
    .we      (mem_we),
    .waddr   (mem_waddr),
    .wlane_n (mem_wlane_n),
    .wword   (mem_wword),
    .raddr   (cur_addr),
    .rword   (mem_rword)
  );

  // output stage: oe_n acts without a clock
  assign drive  = sel && (kind == KIND_READ) && !oe_n;
  assign rvalid = drive;
  assign rdata  = drive ? rd_word : '0;

  // R11: no drive while the internal reset is held
  always_comb begin
    if (!rst_sync_n) begin
      a_r11_quiet_in_reset: assert (!rvalid);
    end
  end

  // R10: a high output enable blanks the port
  a_r10_oe_blanks: assert property (@(posedge clk) disable iff (!rst_sync_n)
    oe_n |-> !rvalid && rdata == '0);

  // R9: a fresh deselecting command stops the drive after the edge
  a_r9_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    en && !adv && (|chip_sel_n) |=> !rvalid);

endmodule

// File: tb/test_ztsram_core.sv
`timescale 1ns/1ps
module test_ztsram_core;

  localparam int K_IDLE = 0, K_RD = 1, K_WR = 2, K_ADV = 3, K_STALL = 4;
  localparam int NROWS = 26;

  // row: {req[3:0], kind[3:0], addr[5:0], bw_n[1:0], ilv, wdata[17:0]}
  localparam logic [34:0] TBL [NROWS] = '{
    {4'd1, 4'd2, 6'd5,  2'b00, 1'b0, 18'h00000},
    {4'd3, 4'd1, 6'd5,  2'b00, 1'b0, 18'h2AAAA},
    {4'd4, 4'd2, 6'd5,  2'b10, 1'b0, 18'h00000},
    {4'd4, 4'd1, 6'd5,  2'b00, 1'b0, 18'h15555},
    {4'd4, 4'd2, 6'd9,  2'b01, 1'b0, 18'h00000},
    {4'd3, 4'd2, 6'd9,  2'b00, 1'b0, 18'h3FFFF},
    {4'd3, 4'd1, 6'd9,  2'b00, 1'b0, 18'h12345},
    {4'd2, 4'd1, 6'd6,  2'b00, 1'b0, 18'h00000},
    {4'd5, 4'd3, 6'd33, 2'b00, 1'b1, 18'h00000},
    {4'd5, 4'd3, 6'd50, 2'b00, 1'b1, 18'h00000},
    {4'd5, 4'd3, 6'd1,  2'b00, 1'b0, 18'h00000},
    {4'd6, 4'd1, 6'd26, 2'b00, 1'b1, 18'h00000},
    {4'd6, 4'd3, 6'd0,  2'b00, 1'b0, 18'h00000},
    {4'd6, 4'd3, 6'd63, 2'b00, 1'b0, 18'h00000},
    {4'd6, 4'd3, 6'd7,  2'b00, 1'b0, 18'h00000},
    {4'd8, 4'd4, 6'd11, 2'b00, 1'b0, 18'h3FFFF},
    {4'd9, 4'd0, 6'd2,  2'b00, 1'b0, 18'h00000},
    {4'd7, 4'd3, 6'd2,  2'b00, 1'b0, 18'h00000},
    {4'd7, 4'd2, 6'd40, 2'b00, 1'b0, 18'h00000},
    {4'd7, 4'd3, 6'd17, 2'b00, 1'b0, 18'h0AAAA},
    {4'd8, 4'd4, 6'd41, 2'b00, 1'b0, 18'h3FFFF},
    {4'd8, 4'd1, 6'd41, 2'b00, 1'b0, 18'h00F0F},
    {4'd1, 4'd1, 6'd40, 2'b00, 1'b0, 18'h00000},
    {4'd2, 4'd1, 6'd41, 2'b00, 1'b0, 18'h00000},
    {4'd9, 4'd0, 6'd3,  2'b00, 1'b0, 18'h00000},
    {4'd9, 4'd1, 6'd3,  2'b00, 1'b0, 18'h11111}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        clk_en_n;
  logic [2:0]  chip_sel_n;
  logic        adv;
  logic        we_n;
  logic [1:0]  byte_we_n;
  logic        order_ilv;
  logic [5:0]  addr;
  logic [17:0] wdata;
  logic        oe_n;
  logic [17:0] rdata;
  logic        rvalid;

  int n_cmp = 0;
  int n_bad = 0;

  // reference model state
  logic [17:0] mdl_mem [64];
  bit          m_sel, m_wr, m_ilv, m_pend;
  bit [5:0]    m_base;
  bit [1:0]    m_beat, m_pbw;

  always #2 clk = ~clk;

  ztsram_core i_ztsram_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_en_n   (clk_en_n),
    .chip_sel_n (chip_sel_n),
    .adv        (adv),
    .we_n       (we_n),
    .byte_we_n  (byte_we_n),
    .order_ilv  (order_ilv),
    .addr       (addr),
    .wdata      (wdata),
    .oe_n       (oe_n),
    .rdata      (rdata),
    .rvalid     (rvalid)
  );

  function automatic string req_name(input int n);
    case (n)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  10: return "R10"; 11: return "R11";
      default: return "R?";
    endcase
  endfunction

  function automatic logic [17:0] pat(input int a);
    return 18'((a * 2731 + 7) ^ (a << 11));
  endfunction

  function automatic bit [5:0] m_addr();
    bit [1:0] lo;
    lo = m_ilv ? (m_base[1:0] ^ m_beat) : (m_base[1:0] + m_beat);
    return {m_base[5:2], lo};
  endfunction

  task automatic model_reset();
    m_sel = 0; m_wr = 0; m_ilv = 0; m_pend = 0;
    m_base = '0; m_beat = '0; m_pbw = '1;
  endtask

  // reference behaviour at one clock edge, from the requirements
  task automatic model_edge();
    bit [5:0] wa;
    if (clk_en_n) return;
    if (m_pend) begin
      wa = m_addr();
      if (!m_pbw[0]) mdl_mem[wa][8:0]  = wdata[8:0];
      if (!m_pbw[1]) mdl_mem[wa][17:9] = wdata[17:9];
    end
    if (adv) begin
      if (m_sel) m_beat = m_beat + 2'd1;
    end else begin
      m_sel  = (chip_sel_n == 3'b000);
      m_wr   = !we_n;
      m_base = addr;
      m_beat = 2'd0;
      m_ilv  = order_ilv;
    end
    m_pend = m_sel && m_wr;
    m_pbw  = byte_we_n;
  endtask

  task automatic check(input string tag);
    logic        ev;
    logic [17:0] ed;
    ev = m_sel && !m_wr && !oe_n;
    ed = ev ? mdl_mem[m_addr()] : 18'h0;
    n_cmp++;
    if (rvalid !== ev || rdata !== ed) begin
      n_bad++;
      $display("FAIL %s: rvalid=%0b rdata=%05h expected rvalid=%0b rdata=%05h",
               tag, rvalid, rdata, ev, ed);
    end
  endtask

  task automatic set_inputs(input int kind, input logic [5:0] a, input logic [1:0] bw,
                            input logic ilv, input logic [17:0] d);
    clk_en_n   = 1'b0;
    adv        = 1'b0;
    chip_sel_n = 3'b000;
    we_n       = 1'b1;
    addr       = a;
    byte_we_n  = bw;
    order_ilv  = ilv;
    wdata      = d;
    case (kind)
      K_IDLE:  begin chip_sel_n = a[0] ? 3'b100 : 3'b010; we_n = 1'b0; end
      K_RD:    we_n = 1'b1;
      K_WR:    we_n = 1'b0;
      K_ADV:   begin adv = 1'b1; chip_sel_n = {1'b1, a[1:0]}; we_n = a[2]; end
      default: begin clk_en_n = 1'b1; we_n = 1'b0; adv = a[3]; end
    endcase
  endtask

  // drive just after a falling edge, model the rising edge, compare at the next falling edge
  task automatic step(input int kind, input logic [5:0] a, input logic [1:0] bw,
                      input logic ilv, input logic [17:0] d, input string tag);
    set_inputs(kind, a, bw, ilv, d);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    set_inputs(K_IDLE, 6'd0, 2'b11, 1'b0, 18'h0);
    model_reset();
    repeat (2) @(negedge clk);
    check("R11");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R11");
  endtask

  initial begin
    #700000;
    n_bad++;
    $display("FAIL watchdog (all requirements): run still active, expected to end");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    oe_n = 1'b0;
    for (int i = 0; i < 64; i++) mdl_mem[i] = '0;
    do_reset();

    // R7 with R11: burst continue right after reset stays deselected
    step(K_ADV, 6'd0, 2'b00, 1'b0, 18'h0, "R7");

    // preload every word with a full write (R1 and R4 full width)
    for (int i = 0; i <= 64; i++) begin
      step(i < 64 ? K_WR : K_IDLE, 6'(i), 2'b00, 1'b0,
           i > 0 ? pat(i - 1) : 18'h0, "R1");
    end
    for (int i = 0; i < 64; i += 9) step(K_RD, 6'(i), 2'b00, 1'b0, 18'h0, "R2");

    // vector table walk
    for (int r = 0; r < NROWS; r++) begin
      step(int'(TBL[r][30:27]), TBL[r][26:21], TBL[r][20:19], TBL[r][18],
           TBL[r][17:0], req_name(int'(TBL[r][34:31])));
    end

    // random mix of reads, writes, bursts, stalls and deselects
    for (int n = 0; n < 3000; n++) begin
      int          k;
      int          pick;
      logic [5:0]  a;
      logic [17:0] d;
      pick = int'($urandom_range(0, 99));
      if      (pick < 30) k = K_RD;
      else if (pick < 58) k = K_WR;
      else if (pick < 80) k = K_ADV;
      else if (pick < 90) k = K_STALL;
      else                k = K_IDLE;
      a    = 6'($urandom_range(0, 63));
      d    = 18'($urandom);
      oe_n = ($urandom_range(0, 9) == 0);
      case (k)
        K_RD:    step(k, a, 2'($urandom), 1'($urandom), d, "R2");
        K_WR:    step(k, a, 2'($urandom), 1'($urandom), d, "R3");
        K_ADV:   step(k, a, 2'($urandom), 1'($urandom), d, "R5");
        K_STALL: step(k, a, 2'($urandom), 1'($urandom), d, "R8");
        default: step(k, a, 2'($urandom), 1'($urandom), d, "R9");
      endcase
    end
    oe_n = 1'b0;

    // R10: output enable acts between edges
    step(K_RD, 6'd20, 2'b00, 1'b0, 18'h0, "R2");
    oe_n = 1'b1;
    #0.4;
    check("R10");
    oe_n = 1'b0;
    #0.4;
    check("R10");
    // R10: a high output enable does not block a write
    oe_n = 1'b1;
    step(K_WR, 6'd21, 2'b00, 1'b0, 18'h0, "R10");
    step(K_IDLE, 6'd0, 2'b00, 1'b0, 18'h1F0F0, "R10");
    oe_n = 1'b0;
    step(K_RD, 6'd21, 2'b00, 1'b0, 18'h0, "R10");

    // R11: reset while a write still waits for its data drops it
    step(K_WR, 6'd12, 2'b00, 1'b0, 18'h0, "R11");
    do_reset();
    step(K_RD, 6'd12, 2'b00, 1'b0, 18'h2C3C3, "R11");
    step(K_RD, 6'd13, 2'b00, 1'b0, 18'h0, "R11");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule